// File: doc/BRIEF.md
# Predicated Paired-Quadword Interleaving Store Sequencer

This block turns one vector store of a register pair into a stream of 128-bit memory writes. On a start pulse it latches two vector registers, a governing predicate, a base address and a quadword index. It then walks the elements from lowest to highest. For every active element it issues two writes to adjacent 16-byte slots: the element from the first register, then the element at the same position in the second register. Each element pair therefore lands in memory as one 32-byte structure.

An inactive element produces no request at all. The memory behind its pair is never addressed, so it keeps its contents and cannot report a fault. Requests leave on a valid/ready port that carries address and data. A one-cycle done pulse closes the operation, and a busy flag covers the whole operation so the issuing pipeline knows when it may send the next start.

The vector length is a parameter. It may be any power of two from 128 to 2048 bits, which gives 1 to 16 quadword elements per register.

Top module: `pair_interleave_store`

## Requirements
- R1: Each accepted request carries exactly one 128-bit element. Element i of the first register (bits 128*i+127 down to 128*i of `vec_a_i`) is written at origin + 32*i.
- R2: Element i of the second register (`vec_b_i`, same bit positions) is written at origin + 32*i + 16. This request is the one accepted directly after the first-register write of the same element.
- R3: The origin equals `base_i + (index_i << 4)`, taken modulo 2^64.
- R4: An element whose predicate bit is 0 produces no request. No request ever carries its addresses. The addresses of later elements do not move because of it.
- R5: The predicate has one bit per byte of the vector. Only bit 16*i of `pred_i` decides whether element i is active. The other 15 bits of each group have no effect.
- R6: Requests are issued in ascending element order. Between one pair and the next active pair, the address advances by 16 + 32*k for some k >= 0.
- R7: While `req_valid_o` is high and `req_ready_i` is low, the valid, address and data outputs hold their values on the next cycle. The sequence advances only on a cycle in which both are high.
- R8: With no active element, no request is issued and `done_o` is high in the cycle right after the start edge.
- R9: After reset, `busy_o`, `req_valid_o` and `done_o` are low. A start seen while `busy_o` is low raises `busy_o` on the next cycle. `busy_o` stays high through the done cycle and drops after it. `req_valid_o` is never high while `busy_o` is low.
- R10: `done_o` is a single-cycle pulse. When the last request is accepted, `done_o` goes high on the next cycle.
- R11: Operands are captured at start. A start pulse, or a change to `vec_a_i`, `vec_b_i`, `pred_i`, `base_i` or `index_i`, while `busy_o` is high has no effect on the requests of the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only while idle |
| vec_a_i | input | VLEN_BITS | First source register, element i at bits 128*i upward |
| vec_b_i | input | VLEN_BITS | Second source register, same layout |
| pred_i | input | VLEN_BITS/8 | Governing predicate, one bit per byte |
| base_i | input | ADDR_W | Base byte address |
| index_i | input | ADDR_W | Index in quadwords |
| req_valid_o | output | 1 | Write request valid |
| req_ready_i | input | 1 | Write request accepted when high together with valid |
| req_addr_o | output | ADDR_W | Byte address of the write |
| req_data_o | output | 128 | Write data, one quadword |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle: acceptance of the final request and the completion of the operation. The bench checks that `done_o` rises exactly one cycle after the last handshake, under every ready pattern and every predicate of a four-element configuration. A start pulse can also meet an operation already in flight. The bench provokes this by pulsing start, and scrambling every operand, in the first busy cycle, which is also the done cycle when no element is active. It judges the result by comparing the full request stream against the one computed from the original operands, and by checking that `busy_o` falls right after the done pulse.

// File: rtl/pis_pkg.sv
package pis_pkg;
    localparam int QW          = 128;  // bits per quadword element
    localparam int QBYTES      = QW / 8;
    localparam int QBYTES_LOG2 = 4;    // index scales by one quadword
    localparam int PAIR_LOG2   = 5;    // one element pair spans 32 bytes

    typedef enum logic {
        SLOT_A = 1'b0,   // element from first register
        SLOT_B = 1'b1    // element from second register
    } slot_e;
endpackage

// File: rtl/pis_mask_extract.sv
module pis_mask_extract #(
    parameter int NELEM  = 4,
    parameter int PRED_W = NELEM * 16
) (
    input  logic [PRED_W-1:0] pred,
    output logic [NELEM-1:0]  active
);
    localparam int GROUP = PRED_W / NELEM;

    for (genvar gi = 0; gi < NELEM; gi++) begin : g_elem
        // lowest bit of each per-byte group governs the element
        assign active[gi] = pred[gi*GROUP];
    end
endmodule

// File: rtl/pis_first_set.sv
module pis_first_set #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pis_lane_pick.sv
module pis_lane_pick #(
    parameter int N  = 4,
    parameter int W  = 128,
    parameter int IW = 2
) (
    input  logic [N*W-1:0] vec,
    input  logic [IW-1:0]  sel,
    output logic [W-1:0]   lane
);
    logic [W-1:0] lanes [N];

    for (genvar gi = 0; gi < N; gi++) begin : g_lane
        assign lanes[gi] = vec[gi*W +: W];
    end

    assign lane = lanes[sel];
endmodule

// File: rtl/pair_interleave_store.sv
module pair_interleave_store
    import pis_pkg::*;
#(
    parameter int VLEN_BITS = 512,
    parameter int ADDR_W    = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [VLEN_BITS-1:0]   vec_a_i,
    input  logic [VLEN_BITS-1:0]   vec_b_i,
    input  logic [VLEN_BITS/8-1:0] pred_i,
    input  logic [ADDR_W-1:0]      base_i,
    input  logic [ADDR_W-1:0]      index_i,
    output logic                   req_valid_o,
    input  logic                   req_ready_i,
    output logic [ADDR_W-1:0]      req_addr_o,
    output logic [QW-1:0]          req_data_o,
    output logic                   busy_o,
    output logic                   done_o
);
    localparam int NELEM  = VLEN_BITS / QW;
    localparam int PRED_W = VLEN_BITS / 8;
    localparam int IW     = (NELEM > 1) ? $clog2(NELEM) : 1;

    typedef struct packed {
        logic                 busy;
        logic                 valid;
        logic                 done;
        slot_e                slot;
        logic [IW-1:0]        elem;
        logic [NELEM-1:0]     pend;
        logic [ADDR_W-1:0]    origin;
        logic [VLEN_BITS-1:0] va;
        logic [VLEN_BITS-1:0] vb;
    } seq_t;

    seq_t s_d, s_q;

    logic [NELEM-1:0] act_mask;
    logic [NELEM-1:0] pend_after;
    logic             first_found, next_found;
    logic [IW-1:0]    first_idx, next_idx;
    logic [QW-1:0]    lane_a, lane_b;
    logic             on_second;
    logic             hs;

    pis_mask_extract #(.NELEM(NELEM), .PRED_W(PRED_W)) u_mask (
        .pred   (pred_i),
        .active (act_mask)
    );

    pis_first_set #(.N(NELEM), .IW(IW)) u_first (
        .vec   (act_mask),
        .found (first_found),
        .idx   (first_idx)
    );

    assign pend_after = s_q.pend & ~(NELEM'(1) << s_q.elem);

    pis_first_set #(.N(NELEM), .IW(IW)) u_next (
        .vec   (pend_after),
        .found (next_found),
        .idx   (next_idx)
    );

    pis_lane_pick #(.N(NELEM), .W(QW), .IW(IW)) u_pick_a (
        .vec  (s_q.va),
        .sel  (s_q.elem),
        .lane (lane_a)
    );

    pis_lane_pick #(.N(NELEM), .W(QW), .IW(IW)) u_pick_b (
        .vec  (s_q.vb),
        .sel  (s_q.elem),
        .lane (lane_b)
    );

    assign hs        = s_q.valid & req_ready_i;
    assign on_second = (s_q.slot == SLOT_B);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.done) begin
            s_d.busy = 1'b0;
        end
        if (!s_q.busy && start_i) begin
            s_d.busy   = 1'b1;
            s_d.va     = vec_a_i;
            s_d.vb     = vec_b_i;
            s_d.origin = base_i + (index_i << QBYTES_LOG2);
            s_d.pend   = act_mask;
            s_d.elem   = first_idx;
            s_d.slot   = SLOT_A;
            s_d.valid  = first_found;
            s_d.done   = !first_found;
        end else if (hs) begin
            if (s_q.slot == SLOT_A) begin
                s_d.slot = SLOT_B;
            end else begin
                s_d.slot = SLOT_A;
                s_d.pend = pend_after;
                if (next_found) begin
                    s_d.elem = next_idx;
                end else begin
                    s_d.valid = 1'b0;
                    s_d.done  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_valid_o = s_q.valid;
    assign req_addr_o  = s_q.origin
                       + (ADDR_W'(s_q.elem) << PAIR_LOG2)
                       + (on_second ? ADDR_W'(QBYTES) : '0);
    assign req_data_o  = on_second ? lane_b : lane_a;
    assign busy_o      = s_q.busy;
    assign done_o      = s_q.done;
endmodule

// File: rtl/pis_checker.sv
module pis_checker #(
    parameter int ADDR_W = 64,
    parameter int DW     = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              req_valid_o,
    input logic              req_ready_i,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic [DW-1:0]     req_data_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              on_second
);
    // R7: request held steady under backpressure
    p_hold_under_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_data_o)));

    // R2: second-register write follows the first at +16
    p_pair_adjacent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i && !on_second) |=>
            (req_valid_o && on_second && req_addr_o == $past(req_addr_o) + ADDR_W'(16)));

    // R6: next pair starts 16 + 32k above the previous second write
    p_next_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i && on_second) |=>
            (!req_valid_o || (!on_second && ((req_addr_o - $past(req_addr_o)) & ADDR_W'(31)) == ADDR_W'(16))));

    // R10: done lasts one cycle
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: done only within a busy operation
    p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R9: no request while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !req_valid_o);

    // R9: accepted start raises busy
    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
endmodule

bind pair_interleave_store pis_checker #(.ADDR_W(ADDR_W), .DW(pis_pkg::QW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_addr_o  (req_addr_o),
    .req_data_o  (req_data_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .on_second   (on_second)
);

// File: tb/sim_pair_interleave_store.sv
`timescale 1ns/1ps
module sim_pair_interleave_store;
    localparam int VL = 512;
    localparam int NE = VL / 128;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [VL-1:0]   vec_a_i = '0, vec_b_i = '0;
    logic [VL/8-1:0] pred_i = '0;
    logic [63:0]     base_i = '0, index_i = '0;
    logic            req_valid_o, req_ready_i = 1'b0;
    logic [63:0]     req_addr_o;
    logic [127:0]    req_data_o;
    logic            busy_o, done_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pair_interleave_store #(.VLEN_BITS(VL), .ADDR_W(64)) u0 (.*);

    function automatic logic [127:0] elem_val(input int sel, input int i, input logic [31:0] seed);
        return {seed, 32'(sel) + 32'hB000_0000, 32'(i), ~seed};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit ready_pat(input int mode, input int cyc);
        case (mode)
            0: return 1'b1;
            1: return cyc[0];
            2: return (cyc % 3) == 2;
            default: return ((cyc * 7 + 3) % 5) < 2;
        endcase
    endfunction

    task automatic run_op(input logic [NE-1:0] m, input logic [63:0] base,
                          input logic [63:0] idx, input int rmode,
                          input bit poke, input logic [31:0] seed);
        logic [63:0]  exp_addr [2*NE];
        logic [127:0] exp_data [2*NE];
        logic [63:0]  origin;
        logic [63:0]  prev_addr;
        logic [127:0] prev_data;
        int n, k, last_hs;
        bit prev_stall, finished;
        origin = base + (idx << 4);
        n = 0;
        for (int i = 0; i < NE; i++) begin
            vec_a_i[i*128 +: 128] = elem_val(0, i, seed);
            vec_b_i[i*128 +: 128] = elem_val(1, i, seed);
            // R5: noise in the non-governing predicate bits
            pred_i[i*16 +: 16] = {15'h7FFF, m[i]};
            if (m[i]) begin
                exp_addr[n] = origin + 64'(32 * i);      exp_data[n] = elem_val(0, i, seed); n++;
                exp_addr[n] = origin + 64'(32 * i + 16); exp_data[n] = elem_val(1, i, seed); n++;
            end
        end
        base_i = base; index_i = idx; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            // R11: scramble every operand while busy
            vec_a_i = ~vec_a_i; vec_b_i = ~vec_b_i; pred_i = '1;
            base_i = ~base; index_i = idx + 64'd5;
        end
        k = 0; last_hs = -1; prev_stall = 1'b0; finished = 1'b0;
        prev_addr = '0; prev_data = '0;
        for (int cyc = 0; cyc < 300 && !finished; cyc++) begin
            req_ready_i = ready_pat(rmode, cyc);
            start_i = poke && (cyc == 0);   // R11: start while busy
            #1;
            chk(busy_o === 1'b1, "R9", "busy during op", 128'(busy_o), 128'd1);
            if (prev_stall)
                chk(req_valid_o === 1'b1 && req_addr_o === prev_addr && req_data_o === prev_data,
                    "R7", "stall hold", 128'(req_addr_o), 128'(prev_addr));
            if (done_o) begin
                chk(k == n, "R10", "request count at done", 128'(k), 128'(n));
                if (n == 0)
                    chk(cyc == 0, "R8", "empty done cycle", 128'(cyc), 128'd0);
                else
                    chk(last_hs == cyc - 1, "R10", "done after last handshake", 128'(cyc), 128'(last_hs + 1));
                chk(req_valid_o === 1'b0, "R10", "valid low at done", 128'(req_valid_o), 128'd0);
                finished = 1'b1;
            end else if (req_valid_o) begin
                if (req_ready_i) begin
                    if (k < n) begin
                        chk(req_addr_o === exp_addr[k], (k % 2 == 0) ? "R1" : "R2", "address",
                            128'(req_addr_o), 128'(exp_addr[k]));
                        chk(req_data_o === exp_data[k], (k % 2 == 0) ? "R1" : "R2", "data",
                            req_data_o, exp_data[k]);
                    end else begin
                        chk(1'b0, "R4", "extra request", 128'(req_addr_o), 128'd0);
                    end
                    k++; last_hs = cyc;
                end
                prev_stall = !req_ready_i;
                prev_addr = req_addr_o; prev_data = req_data_o;
            end else begin
                prev_stall = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        req_ready_i = 1'b0;
        if (!finished) chk(1'b0, "R10", "no done seen", 128'(k), 128'(n));
        #1;
        chk(busy_o === 1'b0 && done_o === 1'b0, "R9", "idle after done",
            128'({busy_o, done_o}), 128'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(busy_o === 1'b0 && req_valid_o === 1'b0 && done_o === 1'b0, "R9", "reset state",
            128'({busy_o, req_valid_o, done_o}), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 R5 R6 R7: sweep every predicate against every ready pattern
        for (int m = 0; m < 16; m++) begin
            for (int r = 0; r < 4; r++) begin
                run_op(4'(m), 64'h1000 + 64'(m) * 64'h1_0007, 64'(m * 3 + r), r,
                       r == 3, 32'(m * 16 + r) ^ 32'h5A5A_0000);
            end
        end
        // R3: origin wraps modulo 2^64
        run_op(4'b1011, 64'h0000_0000_0000_0100, 64'h0FFF_FFFF_FFFF_FFFF, 1, 1'b0, 32'hC0DE_0001);
        run_op(4'b1000, 64'hFFFF_FFFF_FFFF_FF80, 64'd2, 0, 1'b1, 32'hC0DE_0002);
        // R8: all-false predicate with a start while busy
        run_op(4'b0000, 64'h2000, 64'd1, 0, 1'b1, 32'hC0DE_0003);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule